// File: doc/BRIEF.md
# Multi-Channel DMA Register Bank

This block is the register front end for a group of descriptor-driven DMA channels. A simple strobe interface carries a word-aligned byte address, a write enable, a read enable and a 32-bit data word. The upper address bits select a channel window and the next bits select a register in that window. Each channel keeps a control word, a 16-bit status word, a command pointer and three condition-selector words. A descriptor sequencer next to this bank reads these values through a separate combinational view port.

Software changes channel status only through the control register. Each control write carries its own write-enable mask in the upper half of the data word, so single bits can be set or cleared without a read-modify-write. The bank keeps the run and active bits consistent with each other. It gives the sequencer a one-cycle kick when a channel is left active. It gives a one-cycle descriptor-fetch request, with the aligned pointer, when a new command pointer is accepted.

Top module: `dmareg_bank`

## Requirements
- R1: The channel index is addr[11:7] and the register index is addr[6:2]. addr[1:0] is ignored. A write or read reaches only the addressed channel.
- R2: After reset every register of every channel reads as zero, and fetch_req and kick are low.
- R3: A write to register 0 stores the whole word as the control value. It then merges into status as new = (val & mask) | (old & ~mask), where mask = data[31:16] and val = data[15:0] with every bit forced to zero except RUN(15), PAUSE(14), FLUSH(13), WAKE(12) and device status (7:0).
- R4: After that merge, a set RUN bit sets ACTIVE(10) and clears DEAD(11). A set PAUSE bit then clears ACTIVE.
- R5: A control write that takes RUN from 1 to 0 also clears ACTIVE and DEAD in the same update.
- R6: In the cycle after a control write that leaves ACTIVE set, kick is high for one cycle and kick_ch holds the written channel.
- R7: A write to register 3 is ignored while RUN or ACTIVE is set in that channel's status. The stored pointer does not change and no fetch request is raised.
- R8: An accepted write to register 3 stores the data with bits 3:0 cleared. In the next cycle fetch_req is high for one cycle, with fetch_ch and fetch_ptr giving the channel and the aligned pointer.
- R9: Registers 4, 5 and 6 (interrupt, branch and wait selectors) store all 32 written bits and read them back.
- R10: A read returns the addressed register on rd_data one cycle after rd_en and has no side effect. Register 1 returns status zero-extended. Registers 2 and 7 to 31 read as zero and ignore writes, and a write to register 1 is ignored.
- R11: seq_status, seq_cmd_ptr, seq_int_sel, seq_br_sel and seq_wait_sel show the current registers of the channel selected by seq_ch, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en and held until the next read |
| seq_ch | input | 5 | Channel selected for the sequencer view |
| seq_status | output | 16 | Status of the viewed channel |
| seq_cmd_ptr | output | 32 | Command pointer of the viewed channel |
| seq_int_sel | output | 32 | Interrupt selector of the viewed channel |
| seq_br_sel | output | 32 | Branch selector of the viewed channel |
| seq_wait_sel | output | 32 | Wait selector of the viewed channel |
| fetch_req | output | 1 | One-cycle request to fetch a descriptor |
| fetch_ch | output | 5 | Channel of the fetch request |
| fetch_ptr | output | 32 | Aligned descriptor pointer for the fetch |
| kick | output | 1 | One-cycle pulse: channel left active by a control write |
| kick_ch | output | 5 | Channel of the kick |

## Verification
A wrong decode stores data in a neighbouring channel or register. It shows up on the full readback sweep, which reads every index of every channel after each group of writes, and the next read of the wrong location exposes it. A wrong status merge or a wrong run/active rule shows on the kick pulse in the cycle after the control write, and on the status readback two cycles later. That readback is checked against a model of the merge rules after every control word of a fixed sequence applied to all channels. A pointer write that slips past the run lock shows at once as an unexpected fetch_req, and again as a changed pointer on the sequencer view.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int REG_W  = 32;
    localparam int STAT_W = 16;

    // register indices inside a channel window
    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_CPTR = 3;
    localparam int REG_ISEL = 4;
    localparam int REG_BSEL = 5;
    localparam int REG_WSEL = 6;

    // status bit positions
    localparam int B_RUN    = 15;
    localparam int B_PAUSE  = 14;
    localparam int B_FLUSH  = 13;
    localparam int B_WAKE   = 12;
    localparam int B_DEAD   = 11;
    localparam int B_ACTIVE = 10;

    // value bits that a control write may carry into status
    localparam logic [STAT_W-1:0] CTRL_WR_BITS = 16'hF0FF;

    // pointer alignment: low bits forced to zero
    localparam int ALIGN_BITS = 4;

    typedef struct packed {
        logic [REG_W-1:0]  ctrl;
        logic [STAT_W-1:0] stat;
        logic [REG_W-1:0]  cptr;
        logic [REG_W-1:0]  isel;
        logic [REG_W-1:0]  bsel;
        logic [REG_W-1:0]  wsel;
        logic              fetch;
        logic              kick;
    } ch_state_t;

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode #(
    parameter int NUM_CH    = 32,
    parameter int WIN_SHIFT = 7,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int IDX_W    = WIN_SHIFT - 2,
    localparam int ADDR_W   = CH_W + WIN_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch,
    output logic [IDX_W-1:0]  idx,
    output logic              ch_ok
);

    always_comb begin
        ch    = addr[ADDR_W-1:WIN_SHIFT];
        idx   = addr[WIN_SHIFT-1:2];
        ch_ok = (32'(ch) < NUM_CH);
    end

endmodule

// File: rtl/dmareg_ctrl_merge.sv
module dmareg_ctrl_merge
    import dmareg_pkg::*;
(
    input  logic [STAT_W-1:0] old_stat,
    input  logic [REG_W-1:0]  wdata,
    output logic [STAT_W-1:0] new_stat
);

    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] val;
    logic [STAT_W-1:0] merged;

    always_comb begin
        mask   = wdata[REG_W-1:STAT_W];
        val    = wdata[STAT_W-1:0] & CTRL_WR_BITS;
        merged = (val & mask) | (old_stat & ~mask);

        if (merged[B_RUN]) begin
            merged[B_ACTIVE] = 1'b1;
            merged[B_DEAD]   = 1'b0;
        end
        if (merged[B_PAUSE]) begin
            merged[B_ACTIVE] = 1'b0;
        end
        if (old_stat[B_RUN] && !merged[B_RUN]) begin
            merged[B_ACTIVE] = 1'b0;
            merged[B_DEAD]   = 1'b0;
        end
        new_stat = merged;
    end

endmodule

// File: rtl/dmareg_channel.sv
module dmareg_channel
    import dmareg_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output ch_state_t        st
);

    ch_state_t         st_d;
    ch_state_t         st_q;
    logic [STAT_W-1:0] merged_stat;
    logic              ptr_locked;

    dmareg_ctrl_merge u_merge (
        .old_stat (st_q.stat),
        .wdata    (wdata),
        .new_stat (merged_stat)
    );

    assign ptr_locked = st_q.stat[B_RUN] | st_q.stat[B_ACTIVE];

    always_comb begin
        st_d       = st_q;
        st_d.fetch = 1'b0;
        st_d.kick  = 1'b0;
        if (wr_en) begin
            if (idx == IDX_W'(REG_CTRL)) begin
                st_d.ctrl = wdata;
                st_d.stat = merged_stat;
                st_d.kick = merged_stat[B_ACTIVE];
            end else if (idx == IDX_W'(REG_CPTR)) begin
                if (!ptr_locked) begin
                    st_d.cptr  = {wdata[REG_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                    st_d.fetch = 1'b1;
                end
            end else if (idx == IDX_W'(REG_ISEL)) begin
                st_d.isel = wdata;
            end else if (idx == IDX_W'(REG_BSEL)) begin
                st_d.bsel = wdata;
            end else if (idx == IDX_W'(REG_WSEL)) begin
                st_d.wsel = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    // R7
    cptr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_W'(REG_CPTR) && ptr_locked) |=> ($stable(st_q.cptr) && !st_q.fetch));

    // R5
    run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.stat[B_RUN]) |-> (!st_q.stat[B_ACTIVE] && !st_q.stat[B_DEAD]));

    // R10
    status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && idx == IDX_W'(REG_CTRL)) |=> $stable(st_q.stat));

    // R6
    kick_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.kick |-> st_q.stat[B_ACTIVE]);

    // R8
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fetch |-> (st_q.cptr[ALIGN_BITS-1:0] == '0 && $past(wr_en)));

endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
    import dmareg_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int WIN_SHIFT = 7,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int IDX_W    = WIN_SHIFT - 2,
    localparam int ADDR_W   = CH_W + WIN_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [CH_W-1:0]   seq_ch,
    output logic [STAT_W-1:0] seq_status,
    output logic [REG_W-1:0]  seq_cmd_ptr,
    output logic [REG_W-1:0]  seq_int_sel,
    output logic [REG_W-1:0]  seq_br_sel,
    output logic [REG_W-1:0]  seq_wait_sel,
    output logic              fetch_req,
    output logic [CH_W-1:0]   fetch_ch,
    output logic [REG_W-1:0]  fetch_ptr,
    output logic              kick,
    output logic [CH_W-1:0]   kick_ch
);

    typedef struct packed {
        logic [REG_W-1:0] rd_data;
        logic [CH_W-1:0]  wch;
    } top_state_t;

    top_state_t        top_d;
    top_state_t        top_q;

    logic [CH_W-1:0]   dec_ch;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_ok;
    ch_state_t         st_v [NUM_CH];
    logic [NUM_CH-1:0] fetch_v;
    logic [NUM_CH-1:0] kick_v;
    logic [REG_W-1:0]  rd_mux;
    ch_state_t         rd_st;
    ch_state_t         seq_st;
    ch_state_t         w_st;

    dmareg_decode #(
        .NUM_CH    (NUM_CH),
        .WIN_SHIFT (WIN_SHIFT)
    ) u_decode (
        .addr  (addr),
        .ch    (dec_ch),
        .idx   (dec_idx),
        .ch_ok (dec_ok)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic ch_wr;
        assign ch_wr = wr_en && dec_ok && (dec_ch == CH_W'(gi));

        dmareg_channel #(
            .IDX_W (IDX_W)
        ) u_channel (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (ch_wr),
            .idx   (dec_idx),
            .wdata (wr_data),
            .st    (st_v[gi])
        );

        assign fetch_v[gi] = st_v[gi].fetch;
        assign kick_v[gi]  = st_v[gi].kick;
    end

    // channel selection for read, sequencer view and pulse payload
    always_comb begin
        rd_st  = '0;
        seq_st = '0;
        w_st   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (dec_ch == CH_W'(i)) begin
                rd_st = st_v[i];
            end
            if (seq_ch == CH_W'(i)) begin
                seq_st = st_v[i];
            end
            if (top_q.wch == CH_W'(i)) begin
                w_st = st_v[i];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (dec_ok) begin
            if (dec_idx == IDX_W'(REG_CTRL)) begin
                rd_mux = rd_st.ctrl;
            end else if (dec_idx == IDX_W'(REG_STAT)) begin
                rd_mux = REG_W'(rd_st.stat);
            end else if (dec_idx == IDX_W'(REG_CPTR)) begin
                rd_mux = rd_st.cptr;
            end else if (dec_idx == IDX_W'(REG_ISEL)) begin
                rd_mux = rd_st.isel;
            end else if (dec_idx == IDX_W'(REG_BSEL)) begin
                rd_mux = rd_st.bsel;
            end else if (dec_idx == IDX_W'(REG_WSEL)) begin
                rd_mux = rd_st.wsel;
            end
        end
    end

    always_comb begin
        top_d = top_q;
        if (rd_en) begin
            top_d.rd_data = rd_mux;
        end
        if (wr_en) begin
            top_d.wch = dec_ch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign rd_data      = top_q.rd_data;
    assign seq_status   = seq_st.stat;
    assign seq_cmd_ptr  = seq_st.cptr;
    assign seq_int_sel  = seq_st.isel;
    assign seq_br_sel   = seq_st.bsel;
    assign seq_wait_sel = seq_st.wsel;
    assign fetch_req    = |fetch_v;
    assign fetch_ch     = top_q.wch;
    assign fetch_ptr    = w_st.cptr;
    assign kick         = |kick_v;
    assign kick_ch      = top_q.wch;

    // R8
    fetch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_v));

    // R6
    kick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(kick_v));

    // R8
    fetch_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> ($past(wr_en) && $past(dec_ch) == fetch_ch));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/dmareg_bank_bench.sv
`timescale 1ns/1ps
module dmareg_bank_bench;

    localparam int NCH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  seq_ch = '0;
    logic [15:0] seq_status;
    logic [31:0] seq_cmd_ptr, seq_int_sel, seq_br_sel, seq_wait_sel;
    logic        fetch_req;
    logic [4:0]  fetch_ch;
    logic [31:0] fetch_ptr;
    logic        kick;
    logic [4:0]  kick_ch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl [NCH];
    logic [15:0] m_stat [NCH];
    logic [31:0] m_cptr [NCH];
    logic [31:0] m_sel  [NCH][3];

    always #2.5 clk = ~clk;

    dmareg_bank u_dmareg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .seq_ch(seq_ch),
        .seq_status(seq_status), .seq_cmd_ptr(seq_cmd_ptr),
        .seq_int_sel(seq_int_sel), .seq_br_sel(seq_br_sel),
        .seq_wait_sel(seq_wait_sel), .fetch_req(fetch_req),
        .fetch_ch(fetch_ch), .fetch_ptr(fetch_ptr), .kick(kick), .kick_ch(kick_ch)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // status rules from R3, R4, R5
    function automatic logic [15:0] model_merge(logic [15:0] old, logic [31:0] w);
        logic [15:0] m = w[31:16];
        logic [15:0] v = w[15:0] & 16'hF0FF;
        logic [15:0] s = (v & m) | (old & ~m);
        if (s[15]) begin s[10] = 1'b1; s[11] = 1'b0; end
        if (s[14]) s[10] = 1'b0;
        if (old[15] && !s[15]) begin s[10] = 1'b0; s[11] = 1'b0; end
        return s;
    endfunction

    function automatic logic [31:0] model_read(int ch, int idx);
        case (idx)
            0: return m_ctrl[ch];
            1: return {16'h0, m_stat[ch]};
            3: return m_cptr[ch];
            4: return m_sel[ch][0];
            5: return m_sel[ch][1];
            6: return m_sel[ch][2];
            default: return 32'h0;
        endcase
    endfunction

    task automatic wr(input int ch, input int idx, input logic [31:0] data, input logic [1:0] lo);
        logic exp_fetch = 1'b0;
        logic exp_kick = 1'b0;
        if (idx == 0) begin
            m_ctrl[ch] = data;
            m_stat[ch] = model_merge(m_stat[ch], data);
            exp_kick = m_stat[ch][10];
        end else if (idx == 3) begin
            if (!(m_stat[ch][15] || m_stat[ch][10])) begin
                m_cptr[ch] = {data[31:4], 4'h0};
                exp_fetch = 1'b1;
            end
        end else if (idx >= 4 && idx <= 6) begin
            m_sel[ch][idx-4] = data;
        end
        @(negedge clk);
        wr_en = 1'b1;
        addr = {ch[4:0], idx[4:0], lo};
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        check(idx == 3 ? "R7/R8 fetch_req" : "R8 fetch_req", 32'(fetch_req), 32'(exp_fetch));
        if (exp_fetch) begin
            check("R8 fetch_ch", 32'(fetch_ch), 32'(ch));
            check("R8 fetch_ptr", fetch_ptr, m_cptr[ch]);
        end
        check("R6 kick", 32'(kick), 32'(exp_kick));
        if (exp_kick) check("R6 kick_ch", 32'(kick_ch), 32'(ch));
    endtask

    task automatic rd(input int ch, input int idx, input string req);
        @(negedge clk);
        rd_en = 1'b1;
        addr = {ch[4:0], idx[4:0], 2'b00};
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, model_read(ch, idx));
    endtask

    task automatic sweep_all(input string req);
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < 32; i++)
                rd(c, i, req);
    endtask

    task automatic seq_view(input int ch);
        seq_ch = ch[4:0];
        #0.5;
        check("R11 seq_status", 32'(seq_status), 32'(m_stat[ch]));
        check("R11 seq_cmd_ptr", seq_cmd_ptr, m_cptr[ch]);
        check("R11 seq_int_sel", seq_int_sel, m_sel[ch][0]);
        check("R11 seq_br_sel", seq_br_sel, m_sel[ch][1]);
        check("R11 seq_wait_sel", seq_wait_sel, m_sel[ch][2]);
    endtask

    initial begin
        logic [31:0] ctl_seq [12];
        ctl_seq = '{32'h00FF_005A, 32'h8000_8000, 32'h4000_4000, 32'h4000_0000,
                    32'h1000_1000, 32'h2000_2000, 32'h0F00_0F00, 32'h8000_0000,
                    32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 32'h8000_C000};
        for (int c = 0; c < NCH; c++) begin
            m_ctrl[c] = '0; m_stat[c] = '0; m_cptr[c] = '0;
            for (int k = 0; k < 3; k++) m_sel[c][k] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 fetch_req", 32'(fetch_req), 32'h0);
        check("R2 kick", 32'(kick), 32'h0);
        sweep_all("R2 reset");

        // R9 R1 R8 R10: per-channel distinct patterns, odd low address bits
        for (int c = 0; c < NCH; c++) begin
            wr(c, 4, 32'hA500_0000 ^ (c * 32'h0101_0101), 2'b11);
            wr(c, 5, 32'h5A5A_0000 + c * 32'h0000_0137, 2'b01);
            wr(c, 6, ~(c * 32'h1111_1111), 2'b10);
            wr(c, 3, 32'h1000_0000 + c * 32'h0000_0123 + 32'h7, 2'b00);
            wr(c, 1, 32'hFFFF_FFFF, 2'b00);
            wr(c, 2, 32'hDEAD_BEEF, 2'b00);
            wr(c, 9, 32'hCAFE_F00D, 2'b00);
            wr(c, 31, 32'h1234_5678, 2'b00);
        end
        sweep_all("R1/R9/R10 readback");
        for (int c = 0; c < NCH; c++) seq_view(c);

        // R3 R4 R5 R6 R7: control sequence, rotated per channel
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < 12; s++) begin
                wr(c, 0, ctl_seq[(s + c) % 12], 2'b00);
                wr(c, 3, 32'h2000_0000 + s * 32'h40 + c * 32'h9, 2'b00);
                rd(c, 1, "R3/R4/R5 status");
                rd(c, 0, "R3 ctrl word");
                rd(c, 3, "R7 cmd ptr");
            end
            seq_view(c);
        end

        // R5: explicit run-drop from active with dead cleared
        wr(7, 0, 32'hFFFF_0000, 2'b00);
        wr(7, 0, 32'h8000_8000, 2'b00);
        rd(7, 1, "R4 run sets active");
        wr(7, 0, 32'h8000_0000, 2'b00);
        rd(7, 1, "R5 run drop");

        // pseudo-random control and pointer traffic on a few channels
        begin
            logic [31:0] lf = 32'h1ACE_B00C;
            for (int n = 0; n < 400; n++) begin
                int ch;
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                ch = (n % 4) * 9;
                if (lf[3]) wr(ch, 0, lf, 2'b00);
                else wr(ch, 3, lf ^ 32'h5555_AAAA, 2'b00);
                rd(ch, 1, "R3/R4/R5 random status");
            end
        end

        sweep_all("R1/R10 final readback");
        for (int c = 0; c < NCH; c++) seq_view(c);
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule